// File: doc/BRIEF.md
# ECC-Protected Cache RAM Wrapper

This block holds the tag and data storage of a small set-associative cache and guards both against single event upsets. Every tag entry stores one even-parity bit over its valid flag and tag value. A lookup compares the stored tags of one set against a presented tag and reports a hit, the winning way, and whether any entry of that set failed its parity check. Data is held as 64-bit words, four per 32-byte line. Each word has an 8-bit check field: seven Hamming bits and one overall parity bit. Together they correct any single-bit error and detect any double-bit error.

Check bits are produced only when all eight bytes of a word are written in one cycle. A write with a narrower byte strobe changes only the selected bytes. It never reads the old word to recompute the code. Instead it marks that word's check field as not trustworthy, and later reads of that word skip the check and raise no flag. Encoding and decoding are purely combinational around the storage registers, so protection adds no cycle to either path.

A test port can flip one or two chosen bits of a stored codeword, or bit 0 of a stored tag, so that correction and detection can be exercised.

Top module: `cache_ram_guard`

## Requirements
- R1: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high. `rd_data`, `rd_ce` and `rd_ue` belong to that request in that cycle. `rd_ce` and `rd_ue` are low whenever `rd_valid` is low.
- R2: A write with `wr_strb` equal to 8'hFF stores the 64-bit word with freshly generated check bits and marks the word checked. A later read returns the word with both error flags low.
- R3: A write whose strobe is neither all zeros nor all ones changes only the bytes whose strobe bit is set (strobe bit b covers data bits 8b+7..8b). It marks the word unchecked. Reads of an unchecked word return the stored bits unaltered with both flags low, even after injected flips.
- R4: A write with `wr_strb` equal to zero changes neither the stored data nor the word's checked state.
- R5: One flipped bit in a checked word's 72-bit codeword returns the original data, with `rd_ce` high and `rd_ue` low. Injection positions 0..63 are data bits and 64..71 are the check field.
- R6: Two flipped bits in a checked word return the raw stored data, with `rd_ue` high and `rd_ce` low.
- R7: In the cycle after `lk_en`, `lk_valid` is high. `lk_hit` is high when a valid, parity-clean entry of `lk_set` holds `lk_tag`, and `lk_way` then gives the lowest such way. A tag written with `tw_valid` low never hits.
- R8: When any entry of the looked-up set fails its parity check, `lk_perr` is high and that entry cannot hit.
- R9: After reset all outputs are low, every tag entry is invalid, and every data word reads as zero, unchecked and without flags.
- R10: A read in the same cycle as a write to the same word returns the old contents. A write in the same cycle as an injection into the same word wins, and the injection is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Data write request |
| wr_set | input | SET_W | Write set index |
| wr_way | input | WAY_W | Write way |
| wr_gran | input | GRAN_W | Word within the line |
| wr_strb | input | 8 | Byte strobe, bit b covers bits 8b+7..8b |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Data read request |
| rd_set | input | SET_W | Read set index |
| rd_way | input | WAY_W | Read way |
| rd_gran | input | GRAN_W | Read word within line |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 64 | Corrected or raw read data |
| rd_ce | output | 1 | Corrected single-bit error |
| rd_ue | output | 1 | Uncorrectable error |
| tw_en | input | 1 | Tag write request |
| tw_set | input | SET_W | Tag write set |
| tw_way | input | WAY_W | Tag write way |
| tw_tag | input | TAG_W | Tag value |
| tw_valid | input | 1 | Valid flag stored with tag |
| lk_en | input | 1 | Tag lookup request |
| lk_set | input | SET_W | Lookup set |
| lk_tag | input | TAG_W | Tag to match |
| lk_valid | output | 1 | Lookup result present |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | WAY_W | Lowest hitting way |
| lk_perr | output | 1 | Tag parity error in set |
| inj_en | input | 1 | Inject data bit flips |
| inj_set | input | SET_W | Injection set |
| inj_way | input | WAY_W | Injection way |
| inj_gran | input | GRAN_W | Injection word |
| inj_pos_a | input | 7 | First flip position (0..71) |
| inj_pos_b | input | 7 | Second flip position (0..71) |
| inj_dual | input | 1 | Also flip `inj_pos_b` |
| inj_tag | input | 1 | Flip bit 0 of tag at inj_set/inj_way |

## Verification
Read results and their flags are due exactly one clock after the request edge, because one register stage holds the raw word and decoding follows it combinationally. Lookup results share the same one-cycle timing. Writes, tag writes and injections take effect at the edge that samples them, so a read issued in the next cycle observes them. The bench drives every request on a falling edge and samples at the next falling edge. That places each sample midway inside the single cycle in which the result is valid, and away from any clock edge.

// File: rtl/cache_ecc_pkg.sv
package cache_ecc_pkg;

  localparam int WORD_W = 64;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;
  localparam int CW_W   = WORD_W + CHK_W;
  localparam int STRB_W = WORD_W / 8;
  localparam int POS_W  = 7;

  // Positions 1..71 of the Hamming code; powers of two hold Hamming bits,
  // all other positions take data bits in ascending order.
  function automatic logic [CW_W-1:0] cw_spread(input logic [WORD_W-1:0] d,
                                                 input logic [HAM_W-1:0] h);
    logic [CW_W-1:0] cw;
    int k;
    int hb;
    cw = '0;
    k  = 0;
    hb = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) == 0) begin
        cw[p] = h[hb];
        hb++;
      end else begin
        cw[p] = d[k];
        k++;
      end
    end
    return cw;
  endfunction

  function automatic logic [WORD_W-1:0] cw_gather(input logic [CW_W-1:0] cw);
    logic [WORD_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = cw[p];
        k++;
      end
    end
    return d;
  endfunction

  function automatic logic [CW_W-1:0] pos_mask(input int i);
    logic [CW_W-1:0] m;
    for (int p = 0; p < CW_W; p++) m[p] = ((p >> i) & 1) == 1;
    return m;
  endfunction

  function automatic logic [HAM_W-1:0] cw_syndrome(input logic [CW_W-1:0] cw);
    logic [HAM_W-1:0] s;
    for (int i = 0; i < HAM_W; i++) s[i] = ^(cw & pos_mask(i));
    return s;
  endfunction

  function automatic logic [CHK_W-1:0] chk_calc(input logic [WORD_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = cw_syndrome(cw_spread(d, '0));
    return {(^d) ^ (^h), h};
  endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import cache_ecc_pkg::*;
(
  input  logic [WORD_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  assign chk_o = chk_calc(data_i);
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import cache_ecc_pkg::*;
(
  input  logic              check_en,
  input  logic [WORD_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [WORD_W-1:0] data_o,
  output logic              ce_o,
  output logic              ue_o
);
  logic [CW_W-1:0]  cw;
  logic [CW_W-1:0]  fixed;
  logic [HAM_W-1:0] syn;
  logic             odd;

  always_comb begin
    cw     = cw_spread(data_i, chk_i[HAM_W-1:0]);
    syn    = cw_syndrome(cw);
    odd    = ^{data_i, chk_i};
    fixed  = cw;
    data_o = data_i;
    ce_o   = 1'b0;
    ue_o   = 1'b0;
    if (check_en) begin
      if (odd) begin
        if (syn == '0) begin
          ce_o = 1'b1;
        end else if (syn < 7'd72) begin
          fixed[syn] = ~fixed[syn];
          data_o     = cw_gather(fixed);
          ce_o       = 1'b1;
        end else begin
          ue_o = 1'b1;
        end
      end else if (syn != '0) begin
        ue_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/data_store.sv
module data_store
  import cache_ecc_pkg::*;
#(
  parameter int NW = 32,
  localparam int AW = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CHK_W-1:0]  wr_chk,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  input  logic [CW_W-1:0]   inj_mask,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_vld_q,
  output logic [WORD_W-1:0] rd_data_q,
  output logic [CHK_W-1:0]  rd_chk_q,
  output logic              rd_eccv_q,
  output logic              wr_full_evt,
  output logic              wr_part_evt,
  output logic              inj_drop_evt
);
  logic [WORD_W-1:0] mem_d [NW];
  logic [CHK_W-1:0]  mem_c [NW];
  logic [NW-1:0]     mem_v;
  logic              inj_go;

  assign wr_full_evt  = wr_en & (&wr_strb);
  assign wr_part_evt  = wr_en & (|wr_strb) & ~(&wr_strb);
  assign inj_drop_evt = inj_en & wr_en & (|wr_strb) & (inj_addr == wr_addr);
  assign inj_go       = inj_en & ~inj_drop_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin
        mem_d[i] <= '0;
        mem_c[i] <= '0;
      end
      mem_v     <= '0;
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
      rd_chk_q  <= '0;
      rd_eccv_q <= 1'b0;
    end else begin
      if (inj_go) begin
        mem_d[inj_addr] <= mem_d[inj_addr] ^ inj_mask[WORD_W-1:0];
        mem_c[inj_addr] <= mem_c[inj_addr] ^ inj_mask[CW_W-1:WORD_W];
      end
      if (wr_en) begin
        for (int b = 0; b < STRB_W; b++) begin
          if (wr_strb[b]) mem_d[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
      if (wr_full_evt) begin
        mem_c[wr_addr] <= wr_chk;
        mem_v[wr_addr] <= 1'b1;
      end else if (wr_part_evt) begin
        mem_v[wr_addr] <= 1'b0;
      end
      rd_vld_q <= rd_en;
      if (rd_en) begin
        rd_data_q <= mem_d[rd_addr];
        rd_chk_q  <= mem_c[rd_addr];
        rd_eccv_q <= mem_v[rd_addr];
      end
    end
  end
endmodule

// File: rtl/tag_store.sv
module tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NE    = SETS * WAYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tw_en,
  input  logic [SET_W-1:0] tw_set,
  input  logic [WAY_W-1:0] tw_way,
  input  logic [TAG_W-1:0] tw_tag,
  input  logic             tw_valid,
  input  logic             inj_en,
  input  logic [SET_W-1:0] inj_set,
  input  logic [WAY_W-1:0] inj_way,
  input  logic             lk_en,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_valid,
  output logic             lk_hit,
  output logic [WAY_W-1:0] lk_way,
  output logic             lk_perr
);
  logic [TAG_W-1:0] t_tag [NE];
  logic [NE-1:0]    t_v;
  logic [NE-1:0]    t_p;
  logic [WAYS-1:0]  hit_w;
  logic [WAYS-1:0]  perr_w;
  logic [WAY_W-1:0] first_way;
  logic             inj_go;

  assign inj_go = inj_en & ~(tw_en & (tw_set == inj_set) & (tw_way == inj_way));

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SET_W+WAY_W-1:0] idx;
    assign idx       = {lk_set, WAY_W'(w)};
    assign perr_w[w] = ^{t_p[idx], t_v[idx], t_tag[idx]};
    assign hit_w[w]  = t_v[idx] & (t_tag[idx] == lk_tag) & ~perr_w[w];
  end

  always_comb begin
    first_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_w[w]) first_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) t_tag[i] <= '0;
      t_v      <= '0;
      t_p      <= '0;
      lk_valid <= 1'b0;
      lk_hit   <= 1'b0;
      lk_way   <= '0;
      lk_perr  <= 1'b0;
    end else begin
      if (inj_go) t_tag[{inj_set, inj_way}][0] <= ~t_tag[{inj_set, inj_way}][0];
      if (tw_en) begin
        t_tag[{tw_set, tw_way}] <= tw_tag;
        t_v[{tw_set, tw_way}]   <= tw_valid;
        t_p[{tw_set, tw_way}]   <= ^{tw_valid, tw_tag};
      end
      lk_valid <= lk_en;
      lk_hit   <= lk_en & (|hit_w);
      lk_way   <= lk_en ? first_way : '0;
      lk_perr  <= lk_en & (|perr_w);
    end
  end
endmodule

// File: rtl/cache_ram_guard.sv
module cache_ram_guard
  import cache_ecc_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int GRANS = 4,
  parameter int TAG_W = 20,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int GRAN_W = $clog2(GRANS),
  localparam int NW     = SETS * WAYS * GRANS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [GRAN_W-1:0] wr_gran,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [GRAN_W-1:0] rd_gran,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_ce,
  output logic              rd_ue,
  input  logic              tw_en,
  input  logic [SET_W-1:0]  tw_set,
  input  logic [WAY_W-1:0]  tw_way,
  input  logic [TAG_W-1:0]  tw_tag,
  input  logic              tw_valid,
  input  logic              lk_en,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_valid,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output logic              lk_perr,
  input  logic              inj_en,
  input  logic [SET_W-1:0]  inj_set,
  input  logic [WAY_W-1:0]  inj_way,
  input  logic [GRAN_W-1:0] inj_gran,
  input  logic [POS_W-1:0]  inj_pos_a,
  input  logic [POS_W-1:0]  inj_pos_b,
  input  logic              inj_dual,
  input  logic              inj_tag
);
  localparam int AW = $clog2(NW);

  logic [CHK_W-1:0]  wr_chk;
  logic [CW_W-1:0]   inj_mask;
  logic [WORD_W-1:0] rd_data_q;
  logic [CHK_W-1:0]  rd_chk_q;
  logic              rd_eccv_q;
  logic              wr_full_evt;
  logic              wr_part_evt;
  logic              inj_drop_evt;
  logic [AW-1:0]     wr_addr;
  logic [AW-1:0]     rd_addr;
  logic [AW-1:0]     inj_addr;

  assign wr_addr  = {wr_set, wr_way, wr_gran};
  assign rd_addr  = {rd_set, rd_way, rd_gran};
  assign inj_addr = {inj_set, inj_way, inj_gran};
  assign inj_mask = (CW_W'(1) << inj_pos_a) | (inj_dual ? (CW_W'(1) << inj_pos_b) : '0);

  ecc_encoder u_enc (
    .data_i (wr_data),
    .chk_o  (wr_chk)
  );

  data_store #(.NW(NW)) u_data (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_strb      (wr_strb),
    .wr_data      (wr_data),
    .wr_chk       (wr_chk),
    .inj_en       (inj_en),
    .inj_addr     (inj_addr),
    .inj_mask     (inj_mask),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_vld_q     (rd_valid),
    .rd_data_q    (rd_data_q),
    .rd_chk_q     (rd_chk_q),
    .rd_eccv_q    (rd_eccv_q),
    .wr_full_evt  (wr_full_evt),
    .wr_part_evt  (wr_part_evt),
    .inj_drop_evt (inj_drop_evt)
  );

  ecc_decoder u_dec (
    .check_en (rd_valid & rd_eccv_q),
    .data_i   (rd_data_q),
    .chk_i    (rd_chk_q),
    .data_o   (rd_data),
    .ce_o     (rd_ce),
    .ue_o     (rd_ue)
  );

  tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tag (
    .clk      (clk),
    .rst_n    (rst_n),
    .tw_en    (tw_en),
    .tw_set   (tw_set),
    .tw_way   (tw_way),
    .tw_tag   (tw_tag),
    .tw_valid (tw_valid),
    .inj_en   (inj_tag),
    .inj_set  (inj_set),
    .inj_way  (inj_way),
    .lk_en    (lk_en),
    .lk_set   (lk_set),
    .lk_tag   (lk_tag),
    .lk_valid (lk_valid),
    .lk_hit   (lk_hit),
    .lk_way   (lk_way),
    .lk_perr  (lk_perr)
  );
endmodule

// File: rtl/cache_ram_guard_chk.sv
module cache_ram_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       rd_valid,
  input logic       rd_ce,
  input logic       rd_ue,
  input logic       rd_eccv_q,
  input logic       wr_en,
  input logic [7:0] wr_strb,
  input logic       wr_full_evt,
  input logic       wr_part_evt,
  input logic       inj_drop_evt,
  input logic       inj_en,
  input logic       lk_en,
  input logic       lk_valid,
  input logic       lk_hit,
  input logic       lk_perr
);
  assert_rd_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_flag_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ce || rd_ue) |-> rd_valid);
  assert_unchecked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_eccv_q) |-> !(rd_ce || rd_ue));
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ce && rd_ue));
  assert_zero_strobe_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_strb == 8'h00) |-> !(wr_full_evt || wr_part_evt));
  assert_drop_needs_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inj_drop_evt |-> (inj_en && wr_en));
  assert_lk_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> lk_valid);
  assert_lk_result_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit || lk_perr) |-> lk_valid);
endmodule

bind cache_ram_guard cache_ram_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .rd_valid     (rd_valid),
  .rd_ce        (rd_ce),
  .rd_ue        (rd_ue),
  .rd_eccv_q    (rd_eccv_q),
  .wr_en        (wr_en),
  .wr_strb      (wr_strb),
  .wr_full_evt  (wr_full_evt),
  .wr_part_evt  (wr_part_evt),
  .inj_drop_evt (inj_drop_evt),
  .inj_en       (inj_en),
  .lk_en        (lk_en),
  .lk_valid     (lk_valid),
  .lk_hit       (lk_hit),
  .lk_perr      (lk_perr)
);

// File: tb/tb_cache_ram_guard.sv
`timescale 1ns/1ps
module tb_cache_ram_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        wr_en = 0, rd_en = 0, tw_en = 0, tw_valid = 0, lk_en = 0;
  logic        inj_en = 0, inj_dual = 0, inj_tag = 0;
  logic [1:0]  wr_set = 0, rd_set = 0, tw_set = 0, lk_set = 0, inj_set = 0;
  logic        wr_way = 0, rd_way = 0, tw_way = 0, inj_way = 0;
  logic [1:0]  wr_gran = 0, rd_gran = 0, inj_gran = 0;
  logic [7:0]  wr_strb = 0;
  logic [63:0] wr_data = 0;
  logic [19:0] tw_tag = 0, lk_tag = 0;
  logic [6:0]  inj_pos_a = 0, inj_pos_b = 0;
  logic        rd_valid, rd_ce, rd_ue, lk_valid, lk_hit, lk_way, lk_perr;
  logic [63:0] rd_data;

  cache_ram_guard dut (.*);

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [63:0] mdl [4][2][4];

  // fields: set[76:75] way[74] gran[73:72] strb[71:64] data[63:0]
  localparam logic [76:0] VEC [6] = '{
    {2'd0, 1'b0, 2'd0, 8'hFF, 64'h0123_4567_89AB_CDEF},
    {2'd0, 1'b0, 2'd0, 8'h0F, 64'hFFFF_FFFF_0000_0000},
    {2'd1, 1'b1, 2'd3, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D},
    {2'd1, 1'b1, 2'd3, 8'h00, 64'h1111_1111_1111_1111},
    {2'd3, 1'b1, 2'd2, 8'hA5, 64'h8899_AABB_CCDD_EEFF},
    {2'd3, 1'b1, 2'd2, 8'hFF, 64'h0000_0000_0000_0001}
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_wr(input int s, input int w, input int g, input logic [7:0] st,
                          input logic [63:0] d);
    for (int b = 0; b < 8; b++) if (st[b]) mdl[s][w][g][8*b +: 8] = d[8*b +: 8];
  endtask

  // all tasks start and end on a falling edge
  task automatic do_wr(input int s, input int w, input int g, input logic [7:0] st,
                       input logic [63:0] d);
    wr_en = 1; wr_set = 2'(s); wr_way = 1'(w); wr_gran = 2'(g); wr_strb = st; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_wr(s, w, g, st, d);
  endtask

  task automatic do_rd(input int s, input int w, input int g);
    rd_en = 1; rd_set = 2'(s); rd_way = 1'(w); rd_gran = 2'(g);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic do_inj(input int s, input int w, input int g, input int a, input int b,
                        input bit dual);
    inj_en = 1; inj_set = 2'(s); inj_way = 1'(w); inj_gran = 2'(g);
    inj_pos_a = 7'(a); inj_pos_b = 7'(b); inj_dual = dual;
    @(negedge clk);
    inj_en = 0; inj_dual = 0;
  endtask

  task automatic do_tw(input int s, input int w, input logic [19:0] t, input bit v);
    tw_en = 1; tw_set = 2'(s); tw_way = 1'(w); tw_tag = t; tw_valid = v;
    @(negedge clk);
    tw_en = 0;
  endtask

  task automatic do_lk(input int s, input logic [19:0] t);
    lk_en = 1; lk_set = 2'(s); lk_tag = t;
    @(negedge clk);
    lk_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++)
        for (int g = 0; g < 4; g++) mdl[s][w][g] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    check("R9 rd_valid", 64'(rd_valid), 0);
    check("R9 lk_valid/hit/perr", 64'({lk_valid, lk_hit, lk_perr}), 0);
    do_rd(2, 1, 1);
    check("R9 zero word", rd_data, 0);
    check("R9 unwritten valid/ce/ue", 64'({rd_valid, rd_ce, rd_ue}), 64'b100);
    do_lk(0, 20'h0);
    check("R9 invalid tag miss", 64'({lk_valid, lk_hit, lk_perr}), 64'b100);
    check("R1 idle after read", 64'(rd_valid), 0);

    // R2/R3/R4: vector walk
    for (int i = 0; i < 6; i++) begin
      automatic logic [76:0] v = VEC[i];
      do_wr(int'(v[76:75]), int'(v[74]), int'(v[73:72]), v[71:64], v[63:0]);
      do_rd(int'(v[76:75]), int'(v[74]), int'(v[73:72]));
      check("R2/R3/R4 data", rd_data, mdl[v[76:75]][v[74]][v[73:72]]);
      check("R1 flags clean", 64'({rd_valid, rd_ce, rd_ue}), 64'b100);
    end

    // R5: single flips on a checked word (set1 way1 gran3)
    do_inj(1, 1, 3, 5, 0, 0);
    do_rd(1, 1, 3);
    check("R5 corrected data bit5", rd_data, 64'hDEAD_BEEF_CAFE_F00D);
    check("R5 ce/ue", 64'({rd_ce, rd_ue}), 64'b10);
    do_wr(1, 1, 3, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D);
    do_inj(1, 1, 3, 66, 0, 0);
    do_rd(1, 1, 3);
    check("R5 check-bit flip data", rd_data, 64'hDEAD_BEEF_CAFE_F00D);
    check("R5 check-bit ce/ue", 64'({rd_ce, rd_ue}), 64'b10);
    do_wr(1, 1, 3, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D);
    do_inj(1, 1, 3, 63, 0, 0);
    do_rd(1, 1, 3);
    check("R5 top bit corrected", rd_data, 64'hDEAD_BEEF_CAFE_F00D);

    // R6: double flips
    do_wr(1, 1, 3, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D);
    do_inj(1, 1, 3, 3, 40, 1);
    do_rd(1, 1, 3);
    check("R6 raw data", rd_data, 64'hDEAD_BEEF_CAFE_F00D ^ 64'h0000_0100_0000_0008);
    check("R6 ce/ue", 64'({rd_ce, rd_ue}), 64'b01);
    do_wr(1, 1, 3, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D);
    do_inj(1, 1, 3, 10, 71, 1);
    do_rd(1, 1, 3);
    check("R6 data+check raw", rd_data, 64'hDEAD_BEEF_CAFE_F00D ^ 64'h400);
    check("R6 mixed ce/ue", 64'({rd_ce, rd_ue}), 64'b01);

    // R3: unchecked word ignores flips (set0 way0 gran0 after partial write)
    do_inj(0, 0, 0, 0, 0, 0);
    do_rd(0, 0, 0);
    check("R3 unchecked raw", rd_data, 64'h0123_4567_0000_0001);
    check("R3 unchecked no flags", 64'({rd_ce, rd_ue}), 0);
    // R4: zero strobe on unchecked word keeps it unchecked
    do_wr(0, 0, 0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    do_rd(0, 0, 0);
    check("R4 zero strobe data", rd_data, 64'h0123_4567_0000_0001);

    // R10: read concurrent with write returns old data
    wr_en = 1; wr_set = 2; wr_way = 0; wr_gran = 1; wr_strb = 8'hFF; wr_data = 64'h5555_AAAA_5555_AAAA;
    rd_en = 1; rd_set = 2; rd_way = 0; rd_gran = 1;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check("R10 read-before-write", rd_data, 64'h0);
    do_rd(2, 0, 1);
    check("R10 new data", rd_data, 64'h5555_AAAA_5555_AAAA);
    // R10: write beats injection
    wr_en = 1; wr_set = 2; wr_way = 0; wr_gran = 1; wr_strb = 8'hFF; wr_data = 64'h0F0F_0F0F_0F0F_0F0F;
    inj_en = 1; inj_set = 2; inj_way = 0; inj_gran = 1; inj_pos_a = 7'd9; inj_dual = 0;
    @(negedge clk);
    wr_en = 0; inj_en = 0;
    do_rd(2, 0, 1);
    check("R10 inject dropped data", rd_data, 64'h0F0F_0F0F_0F0F_0F0F);
    check("R10 inject dropped flags", 64'({rd_ce, rd_ue}), 0);

    // R7: tag lookup
    do_tw(1, 0, 20'hABCDE, 1);
    do_tw(1, 1, 20'h12345, 1);
    do_lk(1, 20'hABCDE);
    check("R7 hit way0", 64'({lk_valid, lk_hit, lk_way, lk_perr}), 64'b1100);
    do_lk(1, 20'h12345);
    check("R7 hit way1", 64'({lk_valid, lk_hit, lk_way, lk_perr}), 64'b1110);
    do_lk(1, 20'h55555);
    check("R7 miss", 64'({lk_valid, lk_hit, lk_perr}), 64'b100);
    do_tw(2, 0, 20'h0BEEF, 1);
    do_tw(2, 1, 20'h0BEEF, 1);
    do_lk(2, 20'h0BEEF);
    check("R7 lowest way", 64'({lk_hit, lk_way}), 64'b10);
    do_tw(2, 0, 20'h0BEEF, 0);
    do_lk(2, 20'h0BEEF);
    check("R7 invalid skipped", 64'({lk_hit, lk_way}), 64'b11);

    // R8: tag parity
    inj_tag = 1; inj_set = 1; inj_way = 0;
    @(negedge clk);
    inj_tag = 0;
    do_lk(1, 20'hABCDE);
    check("R8 perr no hit", 64'({lk_valid, lk_hit, lk_perr}), 64'b101);
    do_lk(1, 20'h12345);
    check("R8 clean way still hits", 64'({lk_hit, lk_way, lk_perr}), 64'b111);
    do_tw(1, 0, 20'hABCDE, 1);
    do_lk(1, 20'hABCDE);
    check("R8 rewrite clears perr", 64'({lk_hit, lk_way, lk_perr}), 64'b100);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule